// File: doc/BRIEF.md
# SPI clock divisor search

This unit chooses the two clock divisors for a synchronous serial port. Given the rate of the clock feeding the port and the serial clock rate a peripheral can tolerate, it finds an even prescaler and a post-divider such that the resulting serial clock is the fastest one that does not exceed the request. The serial clock equals the input clock divided by the prescaler times one plus the post-divider field. The prescaler is an even number and the post-divider field can be zero. Both results are eight-bit values, ready to be copied into a port's configuration by surrounding logic.

A search is started with a one-cycle `start` pulse that carries both rates. The block first limits the request. Anything above half the input clock is lowered to half the input clock. Anything below the slowest rate the divisors can reach is raised to that rate. It then walks the candidate pairs one per clock: every post-divider value for prescaler 2, then every post-divider value for prescaler 4, and so on. It stops at the first pair that meets the rule and reports through a one-cycle `done` pulse. If no pair meets the rule, which can only happen when the low limit is disabled by parameter, `err` is raised and the previously chosen divisors stay in place.

Top module: `spi_clkdiv_search`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `busy`, `done` and `err` are 0 and `pre_div` and `post_div` are 0.
- R2: On success, `pre_div`/`post_div` hold the first pair (P, S) for which floor(src / (P×(S+1))) ≤ R, where R is the limited request. The pairs are taken in order: P = 2, 4, … PRE_MAX in the outer loop, and S = 0 … POST_CNT−1 in the inner loop. `post_div` carries S itself, not S+1.
- R3: A request at or above floor(src/2) is lowered to floor(src/2), which always yields `pre_div` = 2 and `post_div` = 0 with `err` = 0.
- R4: With LOW_CLAMP = 1, a request below floor(src / (PRE_MAX×POST_CNT)) is raised to that value before the search, and `err` is never raised.
- R5: With LOW_CLAMP = 0, when no pair passes, `done` pulses with `err` = 1 and `pre_div`/`post_div` keep the values from the last successful search.
- R6: Each accepted `start` gives exactly one `done` pulse, one cycle long. `busy` is 1 from the cycle after `start` up to the cycle before `done`, and is 0 in the `done` cycle.
- R7: A `start` that arrives while `busy` is 1 is ignored. The running search completes once, with the operands captured when it was accepted.
- R8: `pre_div` and `post_div` change only in a `done` cycle with `err` = 0. `err` keeps its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request; operands are captured when idle |
| src_hz | input | RATE_W | Input clock rate in hertz, unsigned |
| want_hz | input | RATE_W | Highest acceptable serial clock rate in hertz, unsigned |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last search found no pair (valid from `done`, held) |
| pre_div | output | RES_W | Chosen even prescaler |
| post_div | output | RES_W | Chosen post-divider field (divider minus one) |

## Verification
The bench builds two copies with a prescaler limit of 10 and 8 post-divider values, so that each search covers at most 40 candidates. One copy keeps the low limit and the other has it removed. This small grid lets the bench sweep requests over the whole range for several input rates, from zero up to the full 32-bit value. The sweep includes requests at src/k for k up to 90, which cross both limits and reach pairs late in the order. The copy without the low limit runs into exhausted searches, so the error path and the retention of the previous divisors are exercised with realistic history.

// File: rtl/spi_cdiv_pkg.sv
// Shared types for the SPI clock divisor search.
// Assumes nothing beyond being compiled before the modules that import it.
package spi_cdiv_pkg;

    // Control states of the search sequencer.
    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for start
        ST_DIV,    // computing the slowest reachable rate
        ST_LOAD,   // seeding the candidate walker with the limited request
        ST_SCAN    // one candidate per cycle
    } cdiv_state_e;

endpackage

// File: rtl/cdiv_udiv.sv
// Restoring unsigned divider by a constant denominator, one quotient bit per
// cycle. A go pulse captures the numerator; done pulses W cycles later with
// the quotient on quo, which then holds until the next go.
// Assumes DEN >= 1 and DEN < 2**W.
module cdiv_udiv #(
    parameter int W   = 32,
    parameter int DEN = 65024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem_q;
    logic [W-1:0]  q_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    shifted;
    logic [W:0]    den_w;

    // Next partial remainder: bring down the next numerator bit.
    always_comb begin
        shifted = {rem_q[W-1:0], q_q[W-1]};
        den_w   = (W + 1)'(DEN);
    end

    // Iteration register: one trial subtraction per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            q_q   <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem_q <= '0;
                q_q   <= num;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (shifted >= den_w) begin
                    rem_q <= shifted - den_w;
                    q_q   <= {q_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted;
                    q_q   <= {q_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quo = q_q;

    // R4: the remainder never reaches the denominator between steps.
    a_r4_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (rem_q < den_w));

endmodule

// File: rtl/cdiv_clamp.sv
// Limits a requested rate to [lo, floor(src/2)]. The low bound is applied
// first and the high bound second, so that the high bound wins if they cross.
// Purely combinational.
module cdiv_clamp #(
    parameter int RATE_W = 32
) (
    input  logic [RATE_W-1:0] src,
    input  logic [RATE_W-1:0] want,
    input  logic [RATE_W-1:0] lo,
    output logic [RATE_W-1:0] rate
);
    logic [RATE_W-1:0] hi;

    // Apply both bounds to the request.
    always_comb begin
        hi   = src >> 1;
        rate = want;
        if (rate < lo) rate = lo;
        if (rate > hi) rate = hi;
    end

endmodule

// File: rtl/cdiv_walk.sv
// Candidate walker. After load it presents pair (2,0), and each step_en moves
// it to the next pair in search order. The test floor(src/d) <= r is
// evaluated as src < (r+1)*d. The product is kept in an accumulator that is
// advanced by additions only, so no multiplier or divider is needed per
// candidate.
// Assumes PRE_MAX even with 2 <= PRE_MAX < 2**RES_W, and POST_CNT <= 2**RES_W.
module cdiv_walk #(
    parameter int RATE_W   = 32,
    parameter int PRE_MAX  = 254,
    parameter int POST_CNT = 256,
    parameter int RES_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step_en,
    input  logic [RATE_W-1:0] rate,
    input  logic [RATE_W-1:0] src,
    output logic              hit,
    output logic              last,
    output logic [RES_W-1:0]  pre,
    output logic [RES_W-1:0]  post
);
    localparam int ACC_W = RATE_W + 2 + $clog2(PRE_MAX * POST_CNT + 1);

    logic [RES_W-1:0] pre_q;
    logic [RES_W-1:0] post_q;
    logic [ACC_W-1:0] acc_q;     // (r+1) * pre * (post+1)
    logic [ACC_W-1:0] stride_q;  // (r+1) * pre
    logic [ACC_W-1:0] base2_q;   // (r+1) * 2
    logic [ACC_W-1:0] seed;
    logic [ACC_W-1:0] stride_nx;
    logic             row_end;

    // Seed and next-row values of the running product.
    always_comb begin
        seed      = ACC_W'({1'b0, rate} + (RATE_W + 1)'(1)) << 1;
        stride_nx = stride_q + base2_q;
        row_end   = (post_q == RES_W'(POST_CNT - 1));
    end

    // Walk state: prescaler, post-divider and the matching products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q    <= RES_W'(2);
            post_q   <= '0;
            acc_q    <= '0;
            stride_q <= '0;
            base2_q  <= '0;
        end else if (load) begin
            pre_q    <= RES_W'(2);
            post_q   <= '0;
            acc_q    <= seed;
            stride_q <= seed;
            base2_q  <= seed;
        end else if (step_en) begin
            if (row_end) begin
                pre_q    <= pre_q + RES_W'(2);
                post_q   <= '0;
                stride_q <= stride_nx;
                acc_q    <= stride_nx;
            end else begin
                post_q <= post_q + RES_W'(1);
                acc_q  <= acc_q + stride_q;
            end
        end
    end

    assign hit  = ACC_W'(src) < acc_q;
    assign last = row_end && (pre_q == RES_W'(PRE_MAX));
    assign pre  = pre_q;
    assign post = post_q;

    // R2: the walk stays on the even prescaler grid inside its limits.
    a_r2_grid: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q[0] == 1'b0) && (pre_q >= RES_W'(2)) &&
        (pre_q <= RES_W'(PRE_MAX)) && (post_q <= RES_W'(POST_CNT - 1)));

    // R2: a step never goes past the last candidate.
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load) |-> !last);

endmodule

// File: rtl/spi_clkdiv_search.sv
// SPI clock divisor search, top level. A start pulse while idle captures the
// input clock rate and the request. With LOW_CLAMP set, the slowest reachable
// rate floor(src/(PRE_MAX*POST_CNT)) is first computed by an iterative
// divider. The request is limited, and the pairs are then tested one per
// cycle until the first match or until the grid is exhausted.
// Assumes start is a synchronous single-cycle strobe; starts while busy are
// dropped.
module spi_clkdiv_search
    import spi_cdiv_pkg::*;
#(
    parameter int RATE_W    = 32,
    parameter int PRE_MAX   = 254,
    parameter int POST_CNT  = 256,
    parameter int RES_W     = 8,
    parameter int LOW_CLAMP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] src_hz,
    input  logic [RATE_W-1:0] want_hz,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [RES_W-1:0]  pre_div,
    output logic [RES_W-1:0]  post_div
);
    localparam int DMAX = PRE_MAX * POST_CNT;

    cdiv_state_e       state_q;
    logic [RATE_W-1:0] src_q;
    logic [RATE_W-1:0] want_q;
    logic [RATE_W-1:0] lo_q;
    logic [RATE_W-1:0] rate_lim;
    logic              div_done;
    logic [RATE_W-1:0] div_quo;
    logic              w_hit;
    logic              w_last;
    logic [RES_W-1:0]  w_pre;
    logic [RES_W-1:0]  w_post;
    logic              w_load;
    logic              w_step;

    // Low-limit variant: a divider, or a fixed zero bound.
    generate
        if (LOW_CLAMP != 0) begin : g_low
            logic div_go;
            assign div_go = (state_q == ST_IDLE) && start;
            cdiv_udiv #(.W(RATE_W), .DEN(DMAX)) u_div (
                .clk  (clk),
                .rst_n(rst_n),
                .go   (div_go),
                .num  (src_hz),
                .done (div_done),
                .quo  (div_quo)
            );
        end else begin : g_nolow
            assign div_done = 1'b0;
            assign div_quo  = '0;
        end
    endgenerate

    cdiv_clamp #(.RATE_W(RATE_W)) u_clamp (
        .src (src_q),
        .want(want_q),
        .lo  (lo_q),
        .rate(rate_lim)
    );

    assign w_load = (state_q == ST_LOAD);
    assign w_step = (state_q == ST_SCAN) && !w_hit && !w_last;

    cdiv_walk #(
        .RATE_W  (RATE_W),
        .PRE_MAX (PRE_MAX),
        .POST_CNT(POST_CNT),
        .RES_W   (RES_W)
    ) u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (w_load),
        .step_en(w_step),
        .rate   (rate_lim),
        .src    (src_q),
        .hit    (w_hit),
        .last   (w_last),
        .pre    (w_pre),
        .post   (w_post)
    );

    // Sequencer: capture operands, wait for the bound, scan, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            src_q    <= '0;
            want_q   <= '0;
            lo_q     <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            pre_div  <= '0;
            post_div <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        src_q   <= src_hz;
                        want_q  <= want_hz;
                        state_q <= (LOW_CLAMP != 0) ? ST_DIV : ST_LOAD;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        lo_q    <= div_quo;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    state_q <= ST_SCAN;
                end
                default: begin
                    if (w_hit) begin
                        pre_div  <= w_pre;
                        post_div <= w_post;
                        err      <= 1'b0;
                        done     <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else if (w_last) begin
                        err     <= 1'b1;
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

    // R6: done lasts one cycle.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done marks the cycle in which busy has just dropped.
    a_r6_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R7: operands held during a search despite new starts.
    a_r7_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(src_q) && $stable(want_q)));

    // R8: divisors move only on a successful completion.
    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((pre_div != $past(pre_div)) || (post_div != $past(post_div)))
            |-> (done && !err));

    // R3: a request at or above half the input clock yields the first pair.
    a_r3_top_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && (want_q >= (src_q >> 1)))
            |-> ((pre_div == RES_W'(2)) && (post_div == '0)));

    // R4: with the low limit in place, the search cannot fail.
    a_r4_no_fail: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((LOW_CLAMP == 0) || !err));

endmodule

// File: tb/sim_spi_clkdiv_search.sv
`timescale 1ns/1ps
module sim_spi_clkdiv_search;
    localparam int RW = 32;
    localparam int PM = 10;
    localparam int PC = 8;
    localparam int RS = 8;
    localparam int DM = PM * PC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st0 = 1'b0;
    logic          st1 = 1'b0;
    logic [RW-1:0] src = '0;
    logic [RW-1:0] want = '0;
    logic          b0, d0, e0, b1, d1, e1;
    logic [RS-1:0] p0, q0, p1, q1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ex1p = 0;
    int ex1s = 0;
    bit ex1e = 0;

    spi_clkdiv_search #(.RATE_W(RW), .PRE_MAX(PM), .POST_CNT(PC),
                        .RES_W(RS), .LOW_CLAMP(1)) u0 (
        .clk(clk), .rst_n(rst_n), .start(st0), .src_hz(src), .want_hz(want),
        .busy(b0), .done(d0), .err(e0), .pre_div(p0), .post_div(q0));

    spi_clkdiv_search #(.RATE_W(RW), .PRE_MAX(PM), .POST_CNT(PC),
                        .RES_W(RS), .LOW_CLAMP(0)) u1 (
        .clk(clk), .rst_n(rst_n), .start(st1), .src_hz(src), .want_hz(want),
        .busy(b1), .done(d1), .err(e1), .pre_div(p1), .post_div(q1));

    always #4 clk = ~clk;

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<190000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Reference: limit the request, then scan the grid with real division.
    task automatic model(input logic [RW-1:0] s_hz, input logic [RW-1:0] w_hz,
                         input bit lowc, output int p, output int s,
                         output bit e);
        longint lo, hi, r;
        bit found;
        lo = longint'(s_hz) / DM;
        hi = longint'(s_hz) / 2;
        r  = longint'(w_hz);
        if (lowc && r < lo) r = lo;
        if (r > hi) r = hi;
        found = 0; p = 0; s = 0;
        for (int pp = 2; pp <= PM; pp += 2)
            for (int ss = 0; ss < PC; ss++)
                if (!found && (longint'(s_hz) / (pp * (ss + 1))) <= r) begin
                    found = 1; p = pp; s = ss;
                end
        e = !found;
    endtask

    task automatic run(input logic [RW-1:0] s_hz, input logic [RW-1:0] w_hz,
                       input bit glitch);
        int ep0, es0, ep1, es1, n0, n1, tail;
        bit ee0, ee1;
        int rp0, rq0, rp1, rq1, re0, re1;
        string tag0;
        string tag1;
        model(s_hz, w_hz, 1'b1, ep0, es0, ee0);
        model(s_hz, w_hz, 1'b0, ep1, es1, ee1);
        if (!ee1) begin ex1p = ep1; ex1s = es1; end
        ex1e = ee1;
        if (w_hz >= (s_hz >> 1))      tag0 = "R3";
        else if (w_hz < (s_hz / DM))  tag0 = "R4";
        else                          tag0 = "R2";
        tag1 = ee1 ? "R5" : "R2";
        @(negedge clk);
        src = s_hz; want = w_hz; st0 = 1'b1; st1 = 1'b1;
        @(negedge clk);
        st0 = 1'b0; st1 = 1'b0;
        chk("R6 busy after start u0", b0, 1);
        chk("R6 busy after start u1", b1, 1);
        n0 = 0; n1 = 0; tail = 0;
        rp0 = 0; rq0 = 0; rp1 = 0; rq1 = 0; re0 = 0; re1 = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (glitch && i == 2) begin
                st0 = 1'b1; src = s_hz ^ 32'h0000_5a5a; want = ~w_hz;
            end else if (glitch && i == 3) begin
                st0 = 1'b0; src = s_hz; want = w_hz;
            end
            if (d0) begin
                n0++; rp0 = p0; rq0 = q0; re0 = e0;
                chk("R6 busy low at done u0", b0, 0);
            end
            if (d1) begin
                n1++; rp1 = p1; rq1 = q1; re1 = e1;
                chk("R6 busy low at done u1", b1, 0);
            end
            if (n0 > 0 && n1 > 0) tail++;
            if (tail >= 4) break;
        end
        chk(glitch ? "R7 single done u0" : "R6 single done u0", n0, 1);
        chk("R6 single done u1", n1, 1);
        chk({tag0, " pre u0"}, rp0, ep0);
        chk({tag0, " post u0"}, rq0, es0);
        chk("R4 err u0", re0, 0);
        chk({tag1, " pre u1"}, rp1, ex1p);
        chk({tag1, " post u1"}, rq1, ex1s);
        chk({tag1, " err u1"}, re1, ee1);
        chk("R8 pre held u0", p0, ep0);
        chk("R8 err held u1", e1, ex1e);
    endtask

    logic [RW-1:0] srcs [9] = '{32'd0, 32'd1, 32'd7, 32'd100, 32'd999,
                                 32'd4000, 32'd65535, 32'd123456789,
                                 32'hFFFF_FFFF};

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", b0, 0);
        chk("R1 done in reset", d0, 0);
        chk("R1 err in reset", e1, 0);
        chk("R1 pre in reset", p0, 0);
        chk("R1 post in reset", q1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after release", b1, 0);
        chk("R1 pre after release", p1, 0);
        for (int si = 0; si < 9; si++) begin
            run(srcs[si], 32'd0, 1'b0);
            run(srcs[si], 32'd1, 1'b1);
            run(srcs[si], 32'd2, 1'b0);
            run(srcs[si], srcs[si] >> 1, 1'b0);
            run(srcs[si], (srcs[si] >> 1) + 32'd1, 1'b0);
            run(srcs[si], 32'hFFFF_FFFF, 1'b0);
            for (int k = 1; k <= 90; k++)
                run(srcs[si], srcs[si] / k, (k % 17) == 0);
        end
        finish_run();
    end
endmodule